// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes queued by an upstream producer into asynchronous serial frames on one output line. A 64-entry queue accepts characters through a valid/ready write port. A serialiser takes them from the queue one at a time and sends each as a frame. A frame is one low start bit, then 6, 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line sits high between frames.

The frame shape comes from three mode inputs: character length, parity type and stop-bit count. The serialiser samples them when a frame begins. Bit timing comes from an external bit-tick strobe that is high for one cycle per bit period. Control inputs start and stop the transmitter, flush it, and hold the line in a break (continuously low). Status outputs report a full queue, an empty queue, a frame in progress, and a one-cycle pulse when a write was dropped.

Back-pressure rules for the write port: a beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the queue is full. A beat offered while `in_ready` is low is not held or retried. It is discarded, and `ovf_pulse` goes high for the following cycle.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset `txd` is 1, `st_empty` is 1, `st_full`, `st_active` and `ovf_pulse` are 0, and `in_ready` is 1.
- R2: A frame starts with one low bit, followed by the data bits least significant first. `mode_char` selects the data bit count: 0 gives 8, 2 gives 7, 3 gives 6, and the unused code 1 gives 8.
- R3: `mode_par` selects the bit that follows the data. 0 gives even parity (the data ones plus the parity bit make an even count). 1 gives odd parity. 2 gives a constant 0. 3 gives a constant 1. Codes 4 to 7 send no parity bit.
- R4: `mode_stop` equal to 2 sends two high stop bits. Every other code sends one.
- R5: A new frame begins only while `ctl_en` is 1 and `ctl_dis` is 0. Otherwise queued characters wait and the line stays high.
- R6: The queue holds 64 characters and sends them in write order. `st_full` and `st_empty` report its fill state, and `in_ready` equals the inverse of `st_full`.
- R7: A beat offered while `in_ready` is 0 is dropped and raises `ovf_pulse` for exactly the next cycle.
- R8: `ctl_txrst` empties the queue, abandons any frame in progress, and returns the line to high (break aside) at the next edge. A write in the same cycle is lost.
- R9: A `ctl_brk_start` pulse drives `txd` low until a `ctl_brk_stop` pulse releases it. Each command cancels the other, and the two together change nothing. No frame begins while break is held.
- R10: `st_active` is 1 from the first cycle of the start bit through the end of the last stop bit, and 0 otherwise.
- R11: A frame begins only on a cycle where `bit_tick` is high. Each bit then lasts exactly until the next tick, so the line changes only on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| in_valid | input | 1 | Write port: character offered |
| in_ready | output | 1 | Write port: queue can take a character |
| in_data | input | 8 | Write port: character |
| mode_char | input | 2 | Character length code |
| mode_par | input | 3 | Parity type code |
| mode_stop | input | 2 | Stop-bit code |
| ctl_en | input | 1 | Transmitter enable level |
| ctl_dis | input | 1 | Transmitter disable level, overrides enable |
| ctl_txrst | input | 1 | Flush queue and serialiser |
| ctl_brk_start | input | 1 | Command: begin break |
| ctl_brk_stop | input | 1 | Command: end break |
| txd | output | 1 | Serial line |
| st_full | output | 1 | Queue full |
| st_empty | output | 1 | Queue empty |
| st_active | output | 1 | Frame in progress |
| ovf_pulse | output | 1 | Dropped-write pulse |

## Verification
The checker assumes that `bit_tick` is a single-cycle strobe and that break commands are short pulses. Its line-stability property excludes cycles that carry a tick, a flush or a break command, so inputs may change freely in those cycles. It also assumes that the mode inputs matter only at a frame's first tick. The stimulus therefore changes modes only while the line is idle, raises the tick for one cycle in every four, and drives every input on the falling clock edge. It never issues break start and break stop in the same cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CHAR_W = 8;
  localparam int CNT_W  = $clog2(CHAR_W);
  localparam int NB_W   = $clog2(CHAR_W + 1);

  // Mode codes whose values are decoded by the serialiser.
  localparam logic [1:0] CHAR_7     = 2'd2;
  localparam logic [1:0] CHAR_6     = 2'd3;
  localparam logic [2:0] PAR_EVEN   = 3'd0;
  localparam logic [2:0] PAR_ODD    = 3'd1;
  localparam logic [2:0] PAR_ZERO   = 3'd2;
  localparam logic [2:0] PAR_ONE    = 3'd3;
  localparam logic [1:0] STOP_TWO   = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PARITY,
    S_STOP
  } tx_state_e;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          push_ok, pop_ok;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dis,
  input  logic brk_start,
  input  logic brk_stop,
  output logic run,
  output logic brk_on
);
  assign run = en && !dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       brk_on <= 1'b0;
    else if (brk_start && !brk_stop)  brk_on <= 1'b1;
    else if (brk_stop && !brk_start)  brk_on <= 1'b0;
  end
endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              tick,
  input  logic              run,
  input  logic              brk_on,
  input  logic              have_data,
  input  logic [CHAR_W-1:0] data,
  input  logic [1:0]        char_sel,
  input  logic [2:0]        par_sel,
  input  logic [1:0]        stop_sel,
  output logic              pop,
  output logic              line,
  output logic              active
);
  tx_state_e         state_q;
  logic [CHAR_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NB_W-1:0]   nb_q;
  logic              par_en_q, par_bit_q, two_stop_q, second_q;

  logic [NB_W-1:0]   nb_d;
  logic [CHAR_W-1:0] masked;
  logic              par_en_d, par_bit_d;
  logic              start_ok, frame_end, load;

  // Decode the mode inputs for the character at the head of the queue.
  always_comb begin
    case (char_sel)
      CHAR_7:  nb_d = NB_W'(CHAR_W - 1);
      CHAR_6:  nb_d = NB_W'(CHAR_W - 2);
      default: nb_d = NB_W'(CHAR_W);
    endcase
    for (int i = 0; i < CHAR_W; i++) masked[i] = data[i] && (NB_W'(i) < nb_d);
    par_en_d  = 1'b1;
    case (par_sel)
      PAR_EVEN: par_bit_d = ^masked;
      PAR_ODD:  par_bit_d = ~^masked;
      PAR_ZERO: par_bit_d = 1'b0;
      PAR_ONE:  par_bit_d = 1'b1;
      default: begin
        par_bit_d = 1'b0;
        par_en_d  = 1'b0;
      end
    endcase
  end

  assign start_ok  = tick && run && !brk_on && have_data;
  assign frame_end = (state_q == S_STOP) && tick && (!two_stop_q || second_q);
  assign load      = start_ok && ((state_q == S_IDLE) || frame_end);
  assign pop       = load;
  assign active    = (state_q != S_IDLE);

  always_comb begin
    case (state_q)
      S_START:  line = 1'b0;
      S_DATA:   line = sh_q[0];
      S_PARITY: line = par_bit_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      nb_q       <= NB_W'(CHAR_W);
      par_en_q   <= 1'b0;
      par_bit_q  <= 1'b0;
      two_stop_q <= 1'b0;
      second_q   <= 1'b0;
    end else if (flush) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      second_q   <= 1'b0;
    end else if (load) begin
      state_q    <= S_START;
      sh_q       <= masked;
      cnt_q      <= '0;
      nb_q       <= nb_d;
      par_en_q   <= par_en_d;
      par_bit_q  <= par_bit_d;
      two_stop_q <= (stop_sel == STOP_TWO);
      second_q   <= 1'b0;
    end else if (tick) begin
      case (state_q)
        S_START: state_q <= S_DATA;
        S_DATA: begin
          sh_q <= sh_q >> 1;
          if (NB_W'(cnt_q) == nb_q - NB_W'(1)) begin
            state_q <= par_en_q ? S_PARITY : S_STOP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_PARITY: state_q <= S_STOP;
        S_STOP: begin
          if (two_stop_q && !second_q) second_q <= 1'b1;
          else                         state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic [1:0]        mode_char,
  input  logic [2:0]        mode_par,
  input  logic [1:0]        mode_stop,
  input  logic              ctl_en,
  input  logic              ctl_dis,
  input  logic              ctl_txrst,
  input  logic              ctl_brk_start,
  input  logic              ctl_brk_stop,
  output logic              txd,
  output logic              st_full,
  output logic              st_empty,
  output logic              st_active,
  output logic              ovf_pulse
);
  logic              run, brk_on, pop, line, full, empty;
  logic [CHAR_W-1:0] head;

  uart_tx_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ctl_txrst),
    .push  (in_valid),
    .wdata (in_data),
    .pop   (pop),
    .rdata (head),
    .full  (full),
    .empty (empty)
  );

  uart_tx_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctl_en),
    .dis       (ctl_dis),
    .brk_start (ctl_brk_start),
    .brk_stop  (ctl_brk_stop),
    .run       (run),
    .brk_on    (brk_on)
  );

  uart_tx_serial u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (ctl_txrst),
    .tick      (bit_tick),
    .run       (run),
    .brk_on    (brk_on),
    .have_data (!empty),
    .data      (head),
    .char_sel  (mode_char),
    .par_sel   (mode_par),
    .stop_sel  (mode_stop),
    .pop       (pop),
    .line      (line),
    .active    (st_active)
  );

  assign in_ready = !full;
  assign st_full  = full;
  assign st_empty = empty;
  assign txd      = line && !brk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_pulse <= 1'b0;
    else        ovf_pulse <= in_valid && !in_ready;
  end
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic in_valid,
  input logic in_ready,
  input logic ctl_txrst,
  input logic ctl_brk_start,
  input logic ctl_brk_stop,
  input logic txd,
  input logic st_full,
  input logic st_empty,
  input logic st_active,
  input logic ovf_pulse,
  input logic brk_on
);
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_full && st_empty));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ovf_pulse);

  p_ovf_only_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !in_ready) |=> !ovf_pulse);

  p_flush_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_txrst |=> (st_empty && !st_active));

  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |-> !txd);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_active && !brk_on) |-> txd);

  p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_active) |-> !txd);

  p_start_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_active) |-> $past(bit_tick));

  p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_active && !bit_tick && !ctl_txrst && !ctl_brk_start && !ctl_brk_stop)
      |=> $stable(txd));
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_tick      (bit_tick),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .ctl_txrst     (ctl_txrst),
  .ctl_brk_start (ctl_brk_start),
  .ctl_brk_stop  (ctl_brk_stop),
  .txd           (txd),
  .st_full       (st_full),
  .st_empty      (st_empty),
  .st_active     (st_active),
  .ovf_pulse     (ovf_pulse),
  .brk_on        (brk_on)
);

// File: tb/test_uart_tx_framer.sv
module test_uart_tx_framer;
  localparam int DIV   = 4;
  localparam int DEPTH = 64;

  typedef struct packed {
    logic [7:0] data;
    logic [1:0] chr;
    logic [2:0] par;
    logic [1:0] stp;
    logic [3:0] exp_nb;
    logic       exp_has_par;
    logic       exp_par;
    logic [1:0] exp_nstop;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h55, 2'd0, 3'd0, 2'd0, 4'd8, 1'b1, 1'b0, 2'd1},
    '{8'hA3, 2'd0, 3'd1, 2'd2, 4'd8, 1'b1, 1'b1, 2'd2},
    '{8'hFF, 2'd2, 3'd0, 2'd0, 4'd7, 1'b1, 1'b1, 2'd1},
    '{8'hC5, 2'd3, 3'd1, 2'd0, 4'd6, 1'b1, 1'b1, 2'd1},
    '{8'h3C, 2'd0, 3'd3, 2'd0, 4'd8, 1'b1, 1'b1, 2'd1},
    '{8'h81, 2'd0, 3'd2, 2'd0, 4'd8, 1'b1, 1'b0, 2'd1},
    '{8'h12, 2'd0, 3'd4, 2'd2, 4'd8, 1'b0, 1'b0, 2'd2},
    '{8'h7E, 2'd1, 3'd6, 2'd3, 4'd8, 1'b0, 1'b0, 2'd1}
  };

  logic       clk = 0, rst_n = 0, bit_tick = 0;
  logic       in_valid = 0, in_ready;
  logic [7:0] in_data = 0;
  logic [1:0] mode_char = 0, mode_stop = 0;
  logic [2:0] mode_par = 3'd4;
  logic       ctl_en = 0, ctl_dis = 0, ctl_txrst = 0;
  logic       ctl_brk_start = 0, ctl_brk_stop = 0;
  logic       txd, st_full, st_empty, st_active, ovf_pulse;

  int errors = 0, checks = 0;

  uart_tx_framer i_uart_tx_framer (.*);

  always #2 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      bit_tick = (c == DIV - 1);
      c = (c == DIV - 1) ? 0 : c + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d, input int nb, input bit has_par,
                       input bit pbit, input int nstop, input bit check_idle);
    int w = 0;
    while (txd !== 1'b0 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 4000, "R2 start bit seen", w, 0);
    chk(st_active === 1'b1, "R10 active at start", st_active, 1);
    for (int i = 0; i < nb; i++) begin
      repeat (DIV) @(negedge clk);
      chk(txd === d[i], "R2 data bit", txd, d[i]);
    end
    if (has_par) begin
      repeat (DIV) @(negedge clk);
      chk(txd === pbit, "R3 parity bit", txd, pbit);
    end
    for (int s = 0; s < nstop; s++) begin
      repeat (DIV) @(negedge clk);
      chk(txd === 1'b1, "R4 stop bit", txd, 1);
      chk(st_active === 1'b1, "R10 active in stop", st_active, 1);
    end
    if (check_idle) begin
      repeat (DIV) @(negedge clk);
      chk(txd === 1'b1, "R4 idle after frame", txd, 1);
      chk(st_active === 1'b0, "R10 inactive after frame", st_active, 0);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(st_empty === 1'b1, "R1 empty", st_empty, 1);
    chk(st_full === 1'b0, "R1 full", st_full, 0);
    chk(st_active === 1'b0, "R1 active", st_active, 0);
    chk(in_ready === 1'b1, "R1 ready", in_ready, 1);
    chk(ovf_pulse === 1'b0, "R1 ovf", ovf_pulse, 0);

    ctl_en = 1'b1;
    // Table walk: R2 lengths, R3 parity codes, R4 stop codes
    for (int v = 0; v < NV; v++) begin
      mode_char = VECS[v].chr;
      mode_par  = VECS[v].par;
      mode_stop = VECS[v].stp;
      push(VECS[v].data);
      frame(VECS[v].data, int'(VECS[v].exp_nb), VECS[v].exp_has_par,
            VECS[v].exp_par, int'(VECS[v].exp_nstop), 1'b1);
    end

    // R6 order, back-to-back frames
    mode_char = 2'd0; mode_par = 3'd4; mode_stop = 2'd0;
    push(8'hA5);
    push(8'h5A);
    frame(8'hA5, 8, 1'b0, 1'b0, 1, 1'b0);
    frame(8'h5A, 8, 1'b0, 1'b0, 1, 1'b1);

    // R5 disable overrides enable
    ctl_dis = 1'b1;
    push(8'h33);
    repeat (40) @(negedge clk);
    chk(txd === 1'b1, "R5 held idle", txd, 1);
    chk(st_empty === 1'b0, "R5 char waits", st_empty, 0);
    ctl_dis = 1'b0;
    frame(8'h33, 8, 1'b0, 1'b0, 1, 1'b1);

    // R6 full, R7 overflow drop
    ctl_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) push(8'(i * 3 + 1));
    chk(st_full === 1'b1, "R6 full after 64", st_full, 1);
    chk(in_ready === 1'b0, "R6 not ready when full", in_ready, 0);
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    chk(ovf_pulse === 1'b1, "R7 overflow pulse", ovf_pulse, 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk(ovf_pulse === 1'b0, "R7 pulse one cycle", ovf_pulse, 0);
    ctl_en = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      frame(8'(i * 3 + 1), 8, 1'b0, 1'b0, 1, (i == DEPTH - 1));
    chk(st_empty === 1'b1, "R7 dropped beat absent", st_empty, 1);

    // R8 flush of queued data
    ctl_en = 1'b0;
    push(8'h11); push(8'h22); push(8'h44);
    ctl_txrst = 1'b1;
    @(negedge clk);
    ctl_txrst = 1'b0;
    chk(st_empty === 1'b1, "R8 queue flushed", st_empty, 1);
    ctl_en = 1'b1;
    repeat (60) @(negedge clk);
    chk(txd === 1'b1, "R8 nothing sent after flush", txd, 1);

    // R8 flush mid-frame
    push(8'h00);
    begin
      int w = 0;
      while (txd !== 1'b0 && w < 100) begin @(negedge clk); w++; end
    end
    repeat (DIV * 3) @(negedge clk);
    chk(txd === 1'b0, "R8 frame running", txd, 0);
    ctl_txrst = 1'b1;
    @(negedge clk);
    ctl_txrst = 1'b0;
    chk(txd === 1'b1, "R8 line released", txd, 1);
    chk(st_active === 1'b0, "R8 serialiser idle", st_active, 0);

    // R9 break
    ctl_brk_start = 1'b1;
    @(negedge clk);
    ctl_brk_start = 1'b0;
    chk(txd === 1'b0, "R9 break low", txd, 0);
    push(8'h96);
    repeat (50) @(negedge clk);
    chk(txd === 1'b0, "R9 break held", txd, 0);
    chk(st_empty === 1'b0, "R9 no frame during break", st_empty, 0);
    ctl_brk_stop = 1'b1;
    @(negedge clk);
    ctl_brk_stop = 1'b0;
    chk(txd === 1'b1, "R9 break released", txd, 1);
    frame(8'h96, 8, 1'b0, 1'b0, 1, 1'b1);

    summary();
    $finish;
  end
endmodule